// File: doc/BRIEF.md
# Clock Mode Switching Controller

This block sits beside a clock synthesizer and steers it between four operating states: synthesized-clock operation (locked or still settling), a bypass mode in which the reference input clock feeds the output directly, a sleep mode in which the synthesizer core is switched off and only the bypass path runs, and a full power-down in which no output clock is produced at all. Software writes a control word holding request bits and an output divider value. It reads back the stored word, a source-status bit and a sticky error flag, and uses these for a request/acknowledge handshake on every mode change.

The synthesizer core itself is modelled by two pins: an enable that the block drives and a lock indication that the block watches. The output clock is taken from a glitch-free two-source multiplexer and then passes through a programmable integer divider. The divider value sets both the output frequency and the output duty cycle. Moving between sources never produces a runt pulse. The source-status bit changes only once the multiplexer has completed its switch.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the reference clock drives the output undivided. The core enable is 1, the source-status bit is 0, the error flag is 0, and the control readback is 1 (bypass request set, all other fields 0).
- R2: Control word layout: bit 0 requests bypass, bit 1 requests sleep, bit 2 requests power-down, bits [DIV_W+2:3] hold the divider field. A write with `wr_en` stores the word. `ctrl_rd` returns it in the same layout, except where R8 applies.
- R3: A divider field k gives an output period of (k+1) source periods. For k>0 the high time is floor((k+1)/2) source periods. For k=0 the selected source passes through unchanged.
- R4: While bypass is requested, the output comes from the reference clock and the source-status bit reads 0. After the bypass request is cleared and lock is present, the status bit reads 1 only once the output comes from the synthesized clock.
- R5: After the bypass request is cleared, the block waits while the lock input is low. During that wait the output stays on the reference clock and the status bit stays 0.
- R6: Source changes are glitch-free. The two source enables are never on together, and no output pulse is shorter than half a period of the faster source.
- R7: A sleep request is accepted only while bypass is active: the bypass request is set, the reference clock is selected and the status bit reads 0. Once accepted, the core enable drops and the output keeps running from the reference clock.
- R8: A sleep request made while bypass is not active is discarded. The stored sleep bit stays 0 and the core enable stays 1. The error flag becomes 1 and stays 1 until reset.
- R9: Power-down stops the output cleanly at a period boundary and holds it low. Once the synthesized clock is deselected, the core enable goes to 0 and the status bit reads 0. Clearing power-down restarts the output, and the normal path to the synthesized clock follows.
- R10: A bypass request written in the same cycle in which the lock input first rises takes priority. The synthesized clock is never selected, and the status bit stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference input clock; also clocks the control logic |
| pll_clk | input | 1 | Synthesized clock from the core |
| rst | input | 1 | Synchronous active-high reset, held for several reference cycles |
| wr_en | input | 1 | Stores `wr_data` into the control word |
| wr_data | input | DIV_W+3 | Control word to write (layout in R2) |
| pll_lock | input | 1 | Lock indication from the core |
| core_en | output | 1 | Enable for the synthesizer core |
| clk_out | output | 1 | Divided, gated output clock |
| ctrl_rd | output | DIV_W+3 | Stored control word |
| synth_active | output | 1 | Source status: 1 when the synthesized clock drives the output |
| sleep_err | output | 1 | Sticky flag for a rejected sleep request |

## Verification
The collision of interest is a control write that asks for bypass landing in the very cycle in which the lock input first rises. This is the moment when the lock-wait logic would otherwise commit to the synthesized clock. The bench holds lock low with the bypass request cleared, so the core is already enabled and waiting. It then releases lock and writes the bypass request on the same reference edge. It judges the outcome by watching the status bit for sixty cycles, expecting it to stay 0, and by confirming that the output period still equals the reference period.

// File: rtl/ckm_pkg.sv
`timescale 1ns/100ps
package ckm_pkg;
  // Field positions in the control word (software visible)
  localparam int CTL_BYP   = 0;
  localparam int CTL_SLEEP = 1;
  localparam int CTL_PWD   = 2;
  localparam int CTL_DIV   = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REF  = 2'd1,
    SRC_PLL  = 2'd2
  } src_e;
endpackage

// File: rtl/ckm_sync.sv
`timescale 1ns/100ps
module ckm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= {STAGES{RST_VAL}};
    else     sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ckm_glitch_mux.sv
`timescale 1ns/100ps
module ckm_glitch_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic pll_clk,
  input  logic rst,
  input  logic want_ref,
  input  logic want_pll,
  output logic mclk,
  output logic ref_on,
  output logic pll_on
);
  logic ref_s, ref_en;
  logic pll_s, pll_en;

  // Reference leg: may only open once the synthesized leg is seen closed
  ckm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ref_sync (
    .clk(ref_clk), .rst(rst), .d(want_ref & ~pll_on), .q(ref_s)
  );

  always_ff @(negedge ref_clk) begin
    if (rst) ref_en <= 1'b1;
    else     ref_en <= ref_s;
  end

  // Synthesized leg: may only open once the reference leg is closed
  ckm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pll_sync (
    .clk(pll_clk), .rst(rst), .d(want_pll & ~ref_en), .q(pll_s)
  );

  always_ff @(negedge pll_clk) begin
    if (rst) pll_en <= 1'b0;
    else     pll_en <= pll_s;
  end

  // Synthesized-leg state brought back to the control domain
  ckm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_back_sync (
    .clk(ref_clk), .rst(rst), .d(pll_en), .q(pll_on)
  );

  assign mclk   = (ref_clk & ref_en) | (pll_clk & pll_en);
  assign ref_on = ref_en;

  // R6: the two legs are never open together
  p_excl_r6: assert property (@(posedge ref_clk) disable iff (rst)
    !(ref_en && pll_en));
endmodule

// File: rtl/ckm_out_div.sv
`timescale 1ns/100ps
module ckm_out_div #(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic             halt_req,
  input  logic [DIV_W-1:0] div_m1,
  output logic             clk_out,
  output logic             halted_o
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W:0]   half;
  logic             halt_s, halted_q, halted_n, wrap;
  logic             q_q, gate_q;

  ckm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_halt_sync (
    .clk(mclk), .rst(rst), .d(halt_req), .q(halt_s)
  );

  always_comb begin
    wrap     = (cnt_q >= div_m1);
    cnt_n    = wrap ? '0 : cnt_q + 1'b1;
    halted_n = wrap ? halt_s : halted_q;      // halt only at a period boundary
    half     = ({1'b0, div_m1} + 1'b1) >> 1;
  end

  always_ff @(posedge mclk) begin
    if (rst) begin
      cnt_q    <= '0;
      halted_q <= 1'b0;
      q_q      <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      halted_q <= halted_n;
      q_q      <= ~halted_n & ({1'b0, cnt_n} < half);
    end
  end

  // Low-phase gate for the undivided path
  always_ff @(negedge mclk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= ~halted_q;
  end

  assign clk_out  = (div_m1 == '0) ? (mclk & gate_q) : q_q;
  assign halted_o = halted_q;
endmodule

// File: rtl/ckm_ctrl.sv
`timescale 1ns/100ps
module ckm_ctrl
  import ckm_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CTL_W      = DIV_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             lock_i,
  input  logic             ref_on_i,
  input  logic             pll_on_i,
  input  logic             halted_i,
  output logic             want_ref_o,
  output logic             want_pll_o,
  output logic             halt_req_o,
  output logic             core_en_o,
  output logic [DIV_W-1:0] div_o,
  output logic [CTL_W-1:0] ctrl_o,
  output logic             err_o
);
  logic             byp_q, slp_q, pwd_q, err_q, pick_q, core_q;
  logic [DIV_W-1:0] div_q;
  src_e             tgt_q, norm, nxt;
  logic             halt_ack;
  logic             byp_active, slp_rej, settled, pll_ok;
  logic             byp_n, slp_n, pwd_n;
  logic [DIV_W-1:0] div_n;

  ckm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_halt_ack (
    .clk(clk), .rst(rst), .d(halted_i), .q(halt_ack)
  );

  always_comb begin
    byp_active = byp_q & ref_on_i & ~pll_on_i & (tgt_q == SRC_REF);
    slp_rej    = wr_en & wr_data[CTL_SLEEP] & ~slp_q & ~byp_active;
    byp_n      = wr_en ? wr_data[CTL_BYP] : byp_q;
    pwd_n      = wr_en ? wr_data[CTL_PWD] : pwd_q;
    slp_n      = wr_en ? (wr_data[CTL_SLEEP] & ~slp_rej) : slp_q;
    div_n      = wr_en ? wr_data[CTL_DIV +: DIV_W] : div_q;
    // incoming requests outrank a lock edge in the same cycle
    pll_ok     = ~pwd_n & ~byp_n & ~slp_n & (lock_i | pick_q);
    norm       = pll_ok ? SRC_PLL : SRC_REF;
    nxt        = pwd_n ? (halt_ack ? SRC_NONE : tgt_q) : norm;
    settled    = (ref_on_i == (tgt_q == SRC_REF)) &&
                 (pll_on_i == (tgt_q == SRC_PLL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q  <= 1'b1;
      slp_q  <= 1'b0;
      pwd_q  <= 1'b0;
      div_q  <= '0;
      err_q  <= 1'b0;
      pick_q <= 1'b0;
      core_q <= 1'b1;
      tgt_q  <= SRC_REF;
    end else begin
      byp_q  <= byp_n;
      slp_q  <= slp_n;
      pwd_q  <= pwd_n;
      div_q  <= div_n;
      err_q  <= err_q | slp_rej;
      pick_q <= pll_ok;
      core_q <= ~((slp_n | pwd_n) & ~pll_on_i & (tgt_q != SRC_PLL));
      if (settled) tgt_q <= nxt;
    end
  end

  assign want_ref_o = (tgt_q == SRC_REF);
  assign want_pll_o = (tgt_q == SRC_PLL);
  assign halt_req_o = pwd_q;
  assign core_en_o  = core_q;
  assign div_o      = div_q;
  assign ctrl_o     = {div_q, pwd_q, slp_q, byp_q};
  assign err_o      = err_q;

  // R7: sleep is only ever taken on while bypass is active
  p_sleep_gate_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(slp_q) |-> $past(byp_active));
  // R8: the rejection flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R9: the core is never off while its clock is selected
  p_core_off_r9: assert property (@(posedge clk) disable iff (rst)
    !core_q |-> !pll_on_i);
  // R5: the synthesized source is only committed to with lock present
  p_lock_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pick_q) |-> $past(lock_i));
endmodule

// File: rtl/clkmode_ctrl.sv
`timescale 1ns/100ps
module clkmode_ctrl #(
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CTL_W      = DIV_W + 3
) (
  input  logic             ref_clk,
  input  logic             pll_clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             pll_lock,
  output logic             core_en,
  output logic             clk_out,
  output logic [CTL_W-1:0] ctrl_rd,
  output logic             synth_active,
  output logic             sleep_err
);
  logic             want_ref, want_pll, halt_req, halted;
  logic             mclk, ref_on, pll_on;
  logic [DIV_W-1:0] div_m1;

  ckm_ctrl #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(ref_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .lock_i(pll_lock), .ref_on_i(ref_on), .pll_on_i(pll_on),
    .halted_i(halted), .want_ref_o(want_ref), .want_pll_o(want_pll),
    .halt_req_o(halt_req), .core_en_o(core_en), .div_o(div_m1),
    .ctrl_o(ctrl_rd), .err_o(sleep_err)
  );

  ckm_glitch_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .ref_clk(ref_clk), .pll_clk(pll_clk), .rst(rst),
    .want_ref(want_ref), .want_pll(want_pll),
    .mclk(mclk), .ref_on(ref_on), .pll_on(pll_on)
  );

  ckm_out_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
    .mclk(mclk), .rst(rst), .halt_req(halt_req), .div_m1(div_m1),
    .clk_out(clk_out), .halted_o(halted)
  );

  assign synth_active = pll_on;
endmodule

// File: tb/tb_clkmode_ctrl.sv
`timescale 1ns/100ps
module tb_clkmode_ctrl;
  localparam int  DIV_W = 4;
  localparam int  CTL_W = DIV_W + 3;
  localparam real TREF  = 10.0;   // reference clock period
  localparam real TPLL  = 4.0;    // synthesized clock period

  logic             ref_clk, pll_clk, rst, wr_en, pll_lock, lock_hold;
  logic [CTL_W-1:0] wr_data;
  logic             core_en, clk_out, synth_active, sleep_err;
  logic [CTL_W-1:0] ctrl_rd;

  int  vecs = 0, bad = 0, glitches = 0, edges = 0, lock_cnt = 0;
  bit  armed = 0;
  real last_edge = 0.0;

  clkmode_ctrl #(.DIV_W(DIV_W)) dut (
    .ref_clk(ref_clk), .pll_clk(pll_clk), .rst(rst), .wr_en(wr_en),
    .wr_data(wr_data), .pll_lock(pll_lock), .core_en(core_en),
    .clk_out(clk_out), .ctrl_rd(ctrl_rd), .synth_active(synth_active),
    .sleep_err(sleep_err)
  );

  initial begin
    ref_clk = 1'b0;
    forever #(TREF/2) ref_clk = ~ref_clk;
  end

  // core model: oscillates only while enabled, locks 20 cycles later
  initial begin
    pll_clk = 1'b0;
    #0.5;
    forever begin
      #(TPLL/2);
      pll_clk = core_en ? ~pll_clk : 1'b0;
    end
  end

  always @(posedge ref_clk) begin
    if (!core_en)          lock_cnt <= 0;
    else if (lock_cnt < 20) lock_cnt <= lock_cnt + 1;
  end
  assign pll_lock = (lock_cnt >= 20) && !lock_hold;

  always @(clk_out) begin
    edges = edges + 1;
    if (armed && ($realtime - last_edge) < 1.5) glitches = glitches + 1;
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0.1f expected %0.1f", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit byp, input bit slp, input bit pwd, input int n);
    @(negedge ref_clk);
    wr_en   = 1'b1;
    wr_data = {DIV_W'(n - 1), pwd, slp, byp};
    @(negedge ref_clk);
    wr_en   = 1'b0;
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge clk_out);
    @(posedge clk_out);
    t0 = $realtime;
    @(negedge clk_out);
    t1 = $realtime;
    @(posedge clk_out);
    t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic wait_stat(input bit v, input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge ref_clk);
      if (synth_active == v) begin ok = 1'b1; break; end
    end
  endtask

  function automatic real exp_hi(input int n, input real t);
    return (n == 1) ? t / 2.0 : real'(n / 2) * t;
  endfunction

  task automatic chk_clock(input string req, input int n, input real t);
    real per, hi;
    measure(per, hi);
    chk(per == real'(n) * t, req, $sformatf("period div %0d", n), per, real'(n) * t);
    chk(hi == exp_hi(n, t), req, $sformatf("high time div %0d", n), hi, exp_hi(n, t));
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #(TREF * 150000);
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    bit ok, seen;
    int e0;
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; lock_hold = 1'b0;
    repeat (20) @(posedge ref_clk);
    @(negedge ref_clk) rst = 1'b0;
    repeat (5) @(negedge ref_clk);

    // R1 reset state
    chk(core_en == 1'b1, "R1", "core enable", core_en, 1);
    chk(synth_active == 1'b0, "R1", "status", synth_active, 0);
    chk(sleep_err == 1'b0, "R1", "error flag", sleep_err, 0);
    chk(ctrl_rd == CTL_W'(1), "R1", "readback", ctrl_rd, 1);
    chk_clock("R1", 1, TREF);

    // R3 / R2 divider sweep on the reference clock
    for (int n = 1; n <= 8; n++) begin
      wr(1'b1, 1'b0, 1'b0, n);
      repeat (4) @(negedge ref_clk);
      chk(ctrl_rd == {DIV_W'(n - 1), 3'b001}, "R2", "readback",
          ctrl_rd, {DIV_W'(n - 1), 3'b001});
      chk_clock("R3", n, TREF);
    end

    // R5 leave bypass while lock is held low
    lock_hold = 1'b1;
    wr(1'b0, 1'b0, 1'b0, 2);
    repeat (60) @(negedge ref_clk);
    chk(synth_active == 1'b0, "R5", "status while unlocked", synth_active, 0);
    chk_clock("R5", 2, TREF);

    // R4 / R6 lock arrives: switch to the synthesized clock
    armed = 1'b1;
    lock_hold = 1'b0;
    wait_stat(1'b1, 100, ok);
    chk(ok, "R4", "status after lock", synth_active, 1);
    repeat (10) @(negedge ref_clk);
    chk_clock("R4", 2, TPLL);
    armed = 1'b0;

    // R3 divider sweep on the synthesized clock
    for (int n = 1; n <= 8; n++) begin
      wr(1'b0, 1'b0, 1'b0, n);
      repeat (4) @(negedge ref_clk);
      chk_clock("R3", n, TPLL);
    end

    // R8 sleep outside bypass is discarded
    wr(1'b0, 1'b1, 1'b0, 1);
    repeat (5) @(negedge ref_clk);
    chk(sleep_err == 1'b1, "R8", "error flag", sleep_err, 1);
    chk(ctrl_rd[1] == 1'b0, "R8", "stored sleep bit", ctrl_rd[1], 0);
    chk(core_en == 1'b1, "R8", "core enable", core_en, 1);
    chk(synth_active == 1'b1, "R8", "status", synth_active, 1);
    chk_clock("R8", 1, TPLL);

    // R4 / R6 enter bypass
    armed = 1'b1;
    wr(1'b1, 1'b0, 1'b0, 1);
    wait_stat(1'b0, 100, ok);
    chk(ok, "R4", "status after bypass request", synth_active, 0);
    repeat (5) @(negedge ref_clk);
    chk_clock("R4", 1, TREF);
    armed = 1'b0;

    // R7 sleep accepted from bypass
    wr(1'b1, 1'b1, 1'b0, 1);
    repeat (10) @(negedge ref_clk);
    chk(ctrl_rd[1] == 1'b1, "R7", "stored sleep bit", ctrl_rd[1], 1);
    chk(core_en == 1'b0, "R7", "core enable", core_en, 0);
    chk(sleep_err == 1'b1, "R8", "error flag sticky", sleep_err, 1);
    chk_clock("R7", 1, TREF);

    // R4 / R6 wake and return to the synthesized clock
    armed = 1'b1;
    wr(1'b0, 1'b0, 1'b0, 1);
    wait_stat(1'b1, 200, ok);
    chk(ok, "R4", "status after wake", synth_active, 1);
    chk(core_en == 1'b1, "R7", "core enable after wake", core_en, 1);
    repeat (5) @(negedge ref_clk);
    chk_clock("R4", 1, TPLL);

    // R9 power-down from the synthesized clock, divide by 3
    wr(1'b0, 1'b0, 1'b1, 3);
    repeat (60) @(negedge ref_clk);
    e0 = edges;
    #300;
    chk(edges == e0, "R9", "output edges in power-down", edges - e0, 0);
    chk(clk_out == 1'b0, "R9", "output level", clk_out, 0);
    chk(core_en == 1'b0, "R9", "core enable", core_en, 0);
    chk(synth_active == 1'b0, "R9", "status", synth_active, 0);
    wr(1'b0, 1'b0, 1'b0, 3);
    wait_stat(1'b1, 200, ok);
    chk(ok, "R9", "status after power-up", synth_active, 1);
    repeat (5) @(negedge ref_clk);
    chk_clock("R9", 3, TPLL);
    armed = 1'b0;

    // R10 bypass write in the cycle lock rises
    wr(1'b1, 1'b0, 1'b0, 1);
    wait_stat(1'b0, 100, ok);
    lock_hold = 1'b1;
    wr(1'b0, 1'b0, 1'b0, 1);
    repeat (40) @(negedge ref_clk);
    @(negedge ref_clk);
    lock_hold = 1'b0;
    wr_en     = 1'b1;
    wr_data   = {DIV_W'(0), 3'b001};
    @(negedge ref_clk);
    wr_en = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge ref_clk);
      if (synth_active) seen = 1'b1;
    end
    chk(!seen, "R10", "status stayed 0", seen, 0);
    chk_clock("R10", 1, TREF);

    // R6 no runt pulse during any armed switch
    chk(glitches == 0, "R6", "runt pulses", glitches, 0);

    finish_run();
  end
endmodule